// File: doc/BRIEF.md
# Serial Master Clock Divider

This block makes the serial clock for a controller that drives I2C-style or SPI-style transfers as master. Software places an 8-bit divisor value on the reload input. A write strobe to the transmit buffer starts a down counter. That counter advances on an enable that fires once every two system clocks. Each time the counter passes zero, it reloads from the sampled divisor, flips the serial clock, and raises a one-cycle edge tick. A shifter outside the block uses that tick to launch or capture data. Two rollovers make one serial clock period, so the serial clock runs at the system clock divided by 4 x (reload + 1).

When the controller reports that the operation is done, the counter stops. The serial clock then holds whatever level it had. The next buffer write resumes toggling from that level. In I2C mode, divisor values below 3 are refused: the counter stays idle and a sticky error flag rises. SPI mode accepts every divisor.

Top module: `sbrg_top`

## Requirements
- R1: After reset, scl_o is high, edge_tick_o and err_o are low, and the clock does not toggle until a buffer write arrives.
- R2: A buffer write accepted while idle starts the generator. With divisor R, the first scl_o change comes exactly 2(R+1) system clocks after the clock edge that captured the write, and every later change follows 2(R+1) clocks after the one before.
- R3: One full scl_o period lasts 4(R+1) system clocks: 80 for 0x13, 320 for 0x4F, 104 for 0x19, 40 for 0x09 and 160 for 0x27.
- R4: edge_tick_o is high for exactly the one cycle in which scl_o has just changed, and at no other time.
- R5: An op_done_i pulse stops the generator. scl_o then keeps its level and no tick appears. A later accepted write resumes toggling from the held level.
- R6: With mode_i = 1 (I2C), a buffer write whose divisor is 0, 1 or 2 does not start the generator.
- R7: A refused write sets err_o, which stays high through later valid transfers until reset.
- R8: With mode_i = 0 (SPI), divisors 0, 1 and 2 are accepted and give full periods of 4, 8 and 12 clocks.
- R9: The divisor is sampled when counting starts. Changing reload_i during a transfer does not alter the half-period.
- R10: A buffer write while running is ignored and does not disturb the phase of the serial clock.
- R11: When buf_wr_i and op_done_i arrive in the same idle cycle, op_done_i wins and the generator stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reload_i | input | RW (8) | Divisor value |
| buf_wr_i | input | 1 | Transmit buffer write strobe; starts counting |
| op_done_i | input | 1 | Operation complete strobe; stops counting |
| mode_i | input | 1 | 1 = I2C (divisor checked), 0 = SPI |
| scl_o | output | 1 | Generated serial clock |
| edge_tick_o | output | 1 | One-cycle pulse after each scl_o change |
| err_o | output | 1 | Sticky flag for a refused divisor |

## Verification
The bench times the first and following scl_o edges against 2(R+1) and 4(R+1) for each divisor, counting in system clocks.
- An off-by-one in the reload or the prescaler would shift every measured interval by a constant.
- A tick taken from the wrong pipeline stage would land one cycle away from the edge it marks.
- Latching the divisor continuously, or letting a mid-run write restart the counter, would change the next interval after the disturbance.
- Stopping on op_done_i without freezing the output, or resetting the clock level on the next start, would show as a level change while stopped or as a wrong resumed level.
- A missing or non-sticky error path would let divisors 0 to 2 toggle the clock in I2C mode, or drop err_o during the following valid transfer.

// File: rtl/sbrg_pkg.sv
package sbrg_pkg;

  typedef enum logic {
    MODE_SPI = 1'b0,
    MODE_I2C = 1'b1
  } sbrg_mode_e;

  // Number of system clocks between two serial clock edges.
  function automatic int unsigned half_period_clks(input int unsigned div,
                                                    input int unsigned rld);
    return div * (rld + 1);
  endfunction

  // Whether a divisor may start the generator in the given mode.
  function automatic logic reload_allowed(input sbrg_mode_e  m,
                                          input int unsigned rld,
                                          input int unsigned min_i2c);
    return (m != MODE_I2C) || (rld >= min_i2c);
  endfunction

endpackage

// File: rtl/sbrg_ctrl.sv
module sbrg_ctrl
  import sbrg_pkg::*;
#(
  parameter int unsigned RW      = 8,
  parameter int unsigned MIN_I2C = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload_i,
  input  logic          buf_wr_i,
  input  logic          op_done_i,
  input  sbrg_mode_e    mode_i,
  output logic          run_o,
  output logic          active_o,
  output logic          start_o,
  output logic          err_o,
  output logic [RW-1:0] rld_o
);

  logic          run_q;
  logic          err_q;
  logic [RW-1:0] rld_q;
  logic          valid;
  logic          req;
  logic          reject;

  assign valid    = reload_allowed(mode_i, 32'(reload_i), MIN_I2C);
  assign req      = buf_wr_i && !run_q && !op_done_i;
  assign start_o  = req && valid;
  assign reject   = req && !valid;
  assign active_o = run_q && !op_done_i;
  assign run_o    = run_q;
  assign err_o    = err_q;
  assign rld_o    = rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      err_q <= 1'b0;
      rld_q <= '0;
    end else begin
      if (op_done_i)    run_q <= 1'b0;
      else if (start_o) run_q <= 1'b1;
      if (start_o)      rld_q <= reload_i;
      if (reject)       err_q <= 1'b1;
    end
  end

  // R7: the error flag never clears without reset
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R6: a refused divisor leaves the generator idle
  a_r6_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !run_q);

  // R9: the sampled divisor is frozen while running
  a_r9_reload_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(rld_q));

  // R11: a done strobe always leaves the block idle
  a_r11_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    op_done_i |=> !run_q);

endmodule

// File: rtl/sbrg_prescale.sv
module sbrg_prescale #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic active_i,
  output logic en_o
);

  generate
    if (DIV <= 1) begin : g_nodiv
      assign en_o = active_i;
    end else begin : g_div
      localparam int unsigned PW   = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pc_q <= '0;
        else if (start_i)  pc_q <= '0;
        else if (active_i) pc_q <= (pc_q == LAST) ? '0 : PW'(pc_q + 1'b1);
      end

      assign en_o = active_i && (pc_q == LAST);

      // R2: enables never come on back-to-back cycles
      a_r2_en_spaced: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);
    end
  endgenerate

endmodule

// File: rtl/sbrg_downcnt.sv
module sbrg_downcnt #(
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          en_i,
  input  logic [RW-1:0] load_i,
  input  logic [RW-1:0] rld_i,
  output logic          rollover_o
);

  logic [RW-1:0] cnt_q;

  assign rollover_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start_i)    cnt_q <= load_i;
    else if (rollover_o) cnt_q <= rld_i;
    else if (en_i)       cnt_q <= cnt_q - 1'b1;
  end

  // R2: the count never exceeds the sampled divisor
  a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= rld_i);

endmodule

// File: rtl/sbrg_clkout.sv
module sbrg_clkout #(
  parameter logic SCL_IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rollover_i,
  output logic scl_o,
  output logic tick_o
);

  logic scl_q;
  logic tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= SCL_IDLE;
      tick_q <= 1'b0;
    end else begin
      tick_q <= rollover_i;
      if (rollover_i) scl_q <= ~scl_q;
    end
  end

  assign scl_o  = scl_q;
  assign tick_o = tick_q;

  // R4: a tick only in the cycle right after a level change
  a_r4_tick_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> (scl_q != $past(scl_q)));

  // R4: every level change carries a tick
  a_r4_edge_has_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q != $past(scl_q)) |-> tick_q);

endmodule

// File: rtl/sbrg_top.sv
module sbrg_top
  import sbrg_pkg::*;
#(
  parameter int unsigned RW       = 8,
  parameter int unsigned DIV      = 2,
  parameter int unsigned MIN_I2C  = 3,
  parameter logic        SCL_IDLE = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] reload_i,
  input  logic          buf_wr_i,
  input  logic          op_done_i,
  input  logic          mode_i,
  output logic          scl_o,
  output logic          edge_tick_o,
  output logic          err_o
);

  logic          run;
  logic          active;
  logic          start;
  logic          en;
  logic          rollover;
  logic [RW-1:0] rld;

  sbrg_ctrl #(.RW(RW), .MIN_I2C(MIN_I2C)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reload_i (reload_i),
    .buf_wr_i (buf_wr_i),
    .op_done_i(op_done_i),
    .mode_i   (sbrg_mode_e'(mode_i)),
    .run_o    (run),
    .active_o (active),
    .start_o  (start),
    .err_o    (err_o),
    .rld_o    (rld)
  );

  sbrg_prescale #(.DIV(DIV)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .active_i(active),
    .en_o    (en)
  );

  sbrg_downcnt #(.RW(RW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .en_i      (en),
    .load_i    (reload_i),
    .rld_i     (rld),
    .rollover_o(rollover)
  );

  sbrg_clkout #(.SCL_IDLE(SCL_IDLE)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rollover_i(rollover),
    .scl_o     (scl_o),
    .tick_o    (edge_tick_o)
  );

  // R5: while stopped the serial clock keeps its level
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(scl_o));

  // R2: a rollover only happens while running
  a_r2_roll_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |-> run);

endmodule

// File: tb/sbrg_top_tb.sv
module sbrg_top_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reload = 8'h00;
  logic       buf_wr = 1'b0;
  logic       op_done = 1'b0;
  logic       mode = 1'b1;
  logic       scl;
  logic       tick;
  logic       err;

  int n_chk = 0;
  int n_bad = 0;
  bit tick_ok;

  localparam int LIMIT = 2000;

  always #4 clk = ~clk;

  sbrg_top u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload_i   (reload),
    .buf_wr_i   (buf_wr),
    .op_done_i  (op_done),
    .mode_i     (mode),
    .scl_o      (scl),
    .edge_tick_o(tick),
    .err_o      (err)
  );

  // Two toggles per serial period, each after 2*(r+1) clocks.
  function automatic int exp_half(input int r);
    return 2 * r + 2;
  endfunction
  function automatic int exp_full(input int r);
    return 4 * r + 4;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    buf_wr = 1'b0;
    op_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Pulse a buffer write; returns at the negedge after the capturing edge.
  task automatic start_run(input logic [7:0] r, input logic m);
    @(negedge clk);
    reload = r;
    mode = m;
    buf_wr = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic stop_run();
    op_done = 1'b1;
    @(negedge clk);
    op_done = 1'b0;
  endtask

  // Counts cycles until scl changes; also checks the tick pattern.
  task automatic wait_edge(output int n);
    logic prev;
    prev = scl;
    n = 0;
    do begin
      @(negedge clk);
      buf_wr = 1'b0;
      n++;
      if (tick != (scl != prev)) tick_ok = 1'b0;
    end while (scl == prev && n < LIMIT);
  endtask

  // Watches a window in which nothing may change.
  task automatic quiet(input int cycles, output int changes);
    logic lvl;
    lvl = scl;
    changes = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (scl != lvl || tick) changes++;
    end
  endtask

  task automatic t_reset();
    int c;
    do_reset();
    chk(scl == 1'b1, "R1 scl after reset", int'(scl), 1);
    chk(tick == 1'b0, "R1 tick after reset", int'(tick), 0);
    chk(err == 1'b0, "R1 err after reset", int'(err), 0);
    quiet(30, c);
    chk(c == 0, "R1 idle without write", c, 0);
  endtask

  task automatic t_period(input int r, input logic m, input string req);
    int n1, n2, n3;
    tick_ok = 1'b1;
    start_run(8'(r), m);
    wait_edge(n1);
    chk(n1 == exp_half(r), "R2 first edge delay", n1, exp_half(r));
    wait_edge(n2);
    wait_edge(n3);
    chk(n2 == exp_half(r), "R2 half period", n2, exp_half(r));
    chk(n2 + n3 == exp_full(r), req, n2 + n3, exp_full(r));
    chk(tick_ok, "R4 tick at each edge only", int'(tick_ok), 1);
    stop_run();
  endtask

  task automatic t_freeze();
    int n, c;
    logic lvl;
    do_reset();
    start_run(8'h09, 1'b1);
    wait_edge(n);
    stop_run();
    lvl = scl;
    chk(lvl == 1'b0, "R5 level before stop", int'(lvl), 0);
    quiet(60, c);
    chk(c == 0, "R5 frozen after done", c, 0);
    tick_ok = 1'b1;
    start_run(8'h09, 1'b1);
    wait_edge(n);
    chk(n == 20, "R5 resume timing", n, 20);
    chk(scl == 1'b1, "R5 resumes from held level", int'(scl), 1);
    stop_run();
  endtask

  task automatic t_reject();
    int c, n;
    do_reset();
    for (int r = 0; r < 3; r++) begin
      start_run(8'(r), 1'b1);
      chk(err == 1'b1, "R7 err on refused divisor", int'(err), 1);
      quiet(40, c);
      chk(c == 0, "R6 refused divisor stays idle", c, 0);
    end
    start_run(8'h13, 1'b1);
    wait_edge(n);
    chk(n == 40, "R6 valid divisor after refusal", n, 40);
    chk(err == 1'b1, "R7 err sticky across run", int'(err), 1);
    stop_run();
    do_reset();
    chk(err == 1'b0, "R7 err cleared by reset", int'(err), 0);
  endtask

  task automatic t_midrun();
    int n1, n2, n3;
    do_reset();
    start_run(8'h09, 1'b1);
    wait_edge(n1);
    reload = 8'h4F;
    buf_wr = 1'b1;
    wait_edge(n2);
    chk(n2 == 20, "R10 write while running ignored", n2, 20);
    wait_edge(n3);
    chk(n3 == 20, "R9 divisor sampled at start", n3, 20);
    stop_run();
  endtask

  task automatic t_priority();
    int c;
    do_reset();
    @(negedge clk);
    reload = 8'h09;
    mode = 1'b1;
    buf_wr = 1'b1;
    op_done = 1'b1;
    @(negedge clk);
    buf_wr = 1'b0;
    op_done = 1'b0;
    quiet(50, c);
    chk(c == 0, "R11 done wins over write", c, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    t_reset();
    t_period(8'h13, 1'b1, "R3 period 0x13");
    t_period(8'h4F, 1'b1, "R3 period 0x4F");
    t_period(8'h19, 1'b1, "R3 period 0x19");
    t_period(8'h09, 1'b1, "R3 period 0x09");
    t_period(8'h27, 1'b1, "R3 period 0x27");
    t_period(0, 1'b0, "R8 SPI divisor 0");
    t_period(1, 1'b0, "R8 SPI divisor 1");
    t_period(2, 1'b0, "R8 SPI divisor 2");
    t_freeze();
    t_midrun();
    t_priority();
    t_reject();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule